// File: doc/BRIEF.md
# Two-Pass RAM Self-Test Engine

This engine proves that every word of a synchronous single-port RAM can store both a 0 and a 1 in each bit and that every address reaches its own word. It drives the RAM's address, write data and write enable, and reads the RAM's registered read data one cycle after each read. A pulse on `start` runs the whole test. The result is reported on `done`, `fail` and the first failing address, together with an interrupt line that nothing can mask.

The test has two passes. In the first pass the engine writes an ascending pattern to the words in address order. The value of each word is its address, cut or zero-extended to the data width. It then reads every word back and compares it with that pattern. In the second pass each word is read, and the bitwise inverse of the value read from the RAM is written back. This inverse is taken from the RAM contents, not regenerated. A final sweep then reads every word and compares it with the inverted pattern. The first mismatch ends the test at once.

Top module: `ram_bist`

## Requirements
- R1: Out of reset `done`, `fail`, `irq` and `ram_we` are all low.
- R2: One cycle after `start` is sampled in the idle or finished state, the engine writes word a with the value a mod 2^DATA_W. It does this for a = 0 up to DEPTH-1, one write per cycle.
- R3: After the fill, every address is read in ascending order. Each read value, arriving one cycle later, is compared with that address's pattern.
- R4: In the second pass each address is read in one cycle and written in the next with the bitwise inverse of the value just read. After a fault-free run every word holds the inverse of its pattern.
- R5: A final ascending sweep compares each word with the inverse of its pattern.
- R6: A fault-free run raises `done` exactly 5*DEPTH+1 cycles after the edge that samples `start`, with `fail` low.
- R7: The first mismatch ends the test. In the next cycle `done` and `fail` are high and `fail_addr` holds the mismatching address. Once `done` is high the RAM is not written again.
- R8: `irq` is high exactly when `fail` is high. No input can suppress it.
- R9: `start` has no effect while a test runs. A `start` while finished restarts the test and clears `fail` and `irq` at the same edge.
- R10: While finished and without `start`, `done`, `fail` and `fail_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test (idle or finished only) |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | DATA_W | RAM read data, valid one cycle after the address |
| done | output | 1 | Test finished |
| fail | output | 1 | Test found a mismatch |
| fail_addr | output | AW | Address of the first mismatch |
| irq | output | 1 | Unmaskable RAM-failure interrupt |

## Verification
The hardest cases to reach from the ports are failures that stay hidden in the first pass and only show up once the second pass has inverted each word. The order in which two faults are found also matters: it follows time, not address. The bench models the RAM itself and injects a stuck bit at every address, every bit position and both polarities. For each case it works out whether the pattern bit already disagrees with the stuck value, and from that the address and the cycle at which `done` must rise. Further cases add an address alias that folds the upper half of the RAM onto the lower half, and a pair of faults where the higher address fails earlier in time.

// File: rtl/ram_bist_pkg.sv
package ram_bist_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FILL,
      ST_VER1,
      ST_INV_RD,
      ST_INV_WR,
      ST_VER2,
      ST_TAIL,
      ST_DONE
   } bist_st_e;

   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction
endpackage

// File: rtl/bist_addr_ctr.sv
module bist_addr_ctr #(
   parameter int unsigned DEPTH = 1024,
   parameter int unsigned AW    = ram_bist_pkg::addr_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [AW-1:0] addr,
   output logic          last
);
   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (clr)    addr_q <= '0;
      else if (inc)    addr_q <= addr_q + AW'(1);
   end

   assign addr = addr_q;
   assign last = (addr_q == TOP);

   // R7
   addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_q <= TOP);
endmodule

// File: rtl/bist_pattern.sv
module bist_pattern #(
   parameter int unsigned AW = 10,
   parameter int unsigned DW = 16
) (
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] pat
);
   generate
      if (DW > AW) begin : g_extend
         assign pat = {{(DW - AW){1'b0}}, addr};
      end else if (DW == AW) begin : g_same
         assign pat = addr;
      end else begin : g_trunc
         assign pat = addr[DW-1:0];
      end
   endgenerate
endmodule

// File: rtl/bist_cmp.sv
module bist_cmp #(
   parameter int unsigned AW = 10,
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic [DW-1:0] exp_in,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] rdata,
   output logic          vld,
   output logic          mism,
   output logic [AW-1:0] mism_addr
);
   logic          vld_q;
   logic [DW-1:0] exp_q;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         exp_q  <= '0;
         addr_q <= '0;
      end else begin
         vld_q <= issue;
         if (issue) begin
            exp_q  <= exp_in;
            addr_q <= addr_in;
         end
      end
   end

   assign vld       = vld_q;
   assign mism      = vld_q && (rdata != exp_q);
   assign mism_addr = addr_q;
endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
   import ram_bist_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     last,
   input  logic     mism,
   output bist_st_e state,
   output logic     go,
   output logic     clr,
   output logic     inc,
   output logic     we,
   output logic     issue,
   output logic     inv_wr,
   output logic     ver2,
   output logic     fail
);
   bist_st_e st_q, st_d;
   logic     fail_q;

   always_comb begin
      st_d   = st_q;
      go     = 1'b0;
      clr    = 1'b0;
      inc    = 1'b0;
      we     = 1'b0;
      issue  = 1'b0;
      if (mism) begin
         st_d = ST_DONE;
      end else begin
         unique case (st_q)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  go   = 1'b1;
                  clr  = 1'b1;
                  st_d = ST_FILL;
               end
            end
            ST_FILL: begin
               we = 1'b1;
               if (last) begin
                  clr  = 1'b1;
                  st_d = ST_VER1;
               end else begin
                  inc = 1'b1;
               end
            end
            ST_VER1: begin
               issue = 1'b1;
               if (last) begin
                  clr  = 1'b1;
                  st_d = ST_INV_RD;
               end else begin
                  inc = 1'b1;
               end
            end
            ST_INV_RD: st_d = ST_INV_WR;
            ST_INV_WR: begin
               we = 1'b1;
               if (last) begin
                  clr  = 1'b1;
                  st_d = ST_VER2;
               end else begin
                  inc  = 1'b1;
                  st_d = ST_INV_RD;
               end
            end
            ST_VER2: begin
               issue = 1'b1;
               if (last) st_d = ST_TAIL;
               else      inc  = 1'b1;
            end
            ST_TAIL: st_d = ST_DONE;
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         fail_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (mism)    fail_q <= 1'b1;
         else if (go) fail_q <= 1'b0;
      end
   end

   assign state  = st_q;
   assign inv_wr = (st_q == ST_INV_WR);
   assign ver2   = (st_q == ST_VER2);
   assign fail   = fail_q;

   // R4
   inv_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_INV_WR) |-> ($past(st_q) == ST_INV_RD));
endmodule

// File: rtl/ram_bist.sv
module ram_bist
   import ram_bist_pkg::*;
#(
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned AW     = addr_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [AW-1:0]     ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              ram_we,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              done,
   output logic              fail,
   output logic [AW-1:0]     fail_addr,
   output logic              irq
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ram_bist: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("ram_bist: DATA_W must be at least 1");
      end
      if ((1 << AW) < DEPTH) begin : g_bad_aw
         $error("ram_bist: AW too narrow for DEPTH");
      end
   endgenerate

   bist_st_e          state;
   logic              go, clr, inc, we, issue, inv_wr, ver2, fail_c;
   logic              last, cmp_vld, mism;
   logic [AW-1:0]     addr, mism_addr;
   logic [DATA_W-1:0] pat, exp_val;
   logic [AW-1:0]     fail_addr_q;
   logic              irq_q;

   bist_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .addr(addr), .last(last)
   );

   bist_pattern #(.AW(AW), .DW(DATA_W)) u_pat (.addr(addr), .pat(pat));

   bist_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .last(last), .mism(mism),
      .state(state), .go(go), .clr(clr), .inc(inc), .we(we), .issue(issue),
      .inv_wr(inv_wr), .ver2(ver2), .fail(fail_c)
   );

   assign exp_val = ver2 ? ~pat : pat;

   bist_cmp #(.AW(AW), .DW(DATA_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .issue(issue), .exp_in(exp_val),
      .addr_in(addr), .rdata(ram_rdata), .vld(cmp_vld), .mism(mism),
      .mism_addr(mism_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_addr_q <= '0;
         irq_q       <= 1'b0;
      end else if (mism) begin
         fail_addr_q <= mism_addr;
         irq_q       <= 1'b1;
      end else if (go) begin
         fail_addr_q <= '0;
         irq_q       <= 1'b0;
      end
   end

   assign ram_addr  = addr;
   assign ram_wdata = inv_wr ? ~ram_rdata : pat;
   assign ram_we    = we;
   assign done      = (state == ST_DONE);
   assign fail      = fail_c;
   assign fail_addr = fail_addr_q;
   assign irq       = irq_q;

   // R7
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!ram_we && !cmp_vld));

   // R8
   irq_tracks_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == fail);

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(fail) && $stable(fail_addr)));

   // R2
   fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL && $past(state) == ST_FILL) |-> (ram_addr == $past(ram_addr) + AW'(1)));

   // R9
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> (!fail && !irq && state == ST_FILL));
endmodule

// File: tb/ram_bist_bench.sv
module ram_bist_bench;
   localparam int CLK_P = 10;
   localparam int N     = 16;
   localparam int DW    = 8;
   localparam int AW    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_wdata;
   logic          ram_we;
   logic [DW-1:0] ram_rdata;
   logic          done, fail, irq;
   logic [AW-1:0] fail_addr;

   int total = 0;
   int bad   = 0;
   bit wd_hit = 1'b0;

   logic [DW-1:0] mem [N];
   bit            alias_en = 1'b0;
   bit            fa_en = 1'b0, fb_en = 1'b0;
   int            fa_addr = 0, fb_addr = 0;
   logic [DW-1:0] fa_mask = '0, fa_val = '0, fb_mask = '0, fb_val = '0;

   always #(CLK_P/2) clk = ~clk;

   ram_bist #(.DEPTH(N), .DATA_W(DW)) u_ram_bist (
      .clk(clk), .rst_n(rst_n), .start(start), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
      .done(done), .fail(fail), .fail_addr(fail_addr), .irq(irq)
   );

   function automatic int map_a(input int a);
      return alias_en ? (a % (N/2)) : a;
   endfunction

   function automatic logic [DW-1:0] store_v(input int a, input logic [DW-1:0] d);
      logic [DW-1:0] v = d;
      if (fa_en && a == fa_addr) v = (v & ~fa_mask) | (fa_val & fa_mask);
      if (fb_en && a == fb_addr) v = (v & ~fb_mask) | (fb_val & fb_mask);
      return v;
   endfunction

   always_ff @(posedge clk) begin
      if (ram_we) mem[map_a(int'(ram_addr))] <= store_v(map_a(int'(ram_addr)), ram_wdata);
      ram_rdata <= mem[map_a(int'(ram_addr))];
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run(input bit exp_fail, input int exp_addr, input int exp_cnt,
                      input bit mid_start, input bit full_chk);
      int cnt = 0;
      bit seq_ok = 1'b1;
      bit clr_ok = 1'b1;
      bit quiet = 1'b1;
      int hold_addr;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (!done && cnt < 2000) begin
         cnt++;
         if (cnt == 1 && (fail || irq)) clr_ok = 1'b0;
         if (cnt <= N && !(ram_we && int'(ram_addr) == cnt - 1 &&
             ram_wdata == DW'(cnt - 1))) seq_ok = 1'b0;
         if (mid_start && cnt == 20) start = 1'b1;
         if (mid_start && cnt == 21) start = 1'b0;
         @(negedge clk);
      end
      // R6 R7: done timing
      chk(cnt == exp_cnt, "R6/R7 cycles to done", cnt, exp_cnt);
      // R7
      chk(fail == exp_fail, "R7 fail flag", int'(fail), int'(exp_fail));
      if (exp_fail) chk(int'(fail_addr) == exp_addr, "R7 fail_addr", int'(fail_addr), exp_addr);
      // R8
      chk(irq == fail, "R8 irq follows fail", int'(irq), int'(fail));
      // R9
      chk(clr_ok, "R9 start clears fail", 0, 1);
      if (full_chk) begin
         // R2
         chk(seq_ok, "R2 fill sequence", 0, 1);
         // R4
         for (int a = 0; a < N; a++)
            chk(mem[a] == ~DW'(a), "R4 final contents", int'(mem[a]), int'(~DW'(a)));
      end
      hold_addr = int'(fail_addr);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (ram_we || !done || int'(fail_addr) != hold_addr || fail != exp_fail) quiet = 1'b0;
      end
      // R10
      chk(quiet, "R10 hold and no writes after done", 0, 1);
   endtask

   initial begin
      #(CLK_P * 200000);
      wd_hit = 1'b1;
   end

   initial begin : main
      fork
         begin
            #(CLK_P*3);
            // R1
            chk(!done && !fail && !irq && !ram_we, "R1 reset state",
                int'({done, fail, irq, ram_we}), 0);
            @(negedge clk) rst_n = 1'b1;
            // R6 R3 R5: fault-free run, with R9 start ignored mid-run
            run(1'b0, 0, 5*N + 1, 1'b0, 1'b1);
            run(1'b0, 0, 5*N + 1, 1'b1, 1'b1);
            // R3 R5 R7: stuck bits at every address, bit and polarity
            for (int a = 0; a < N; a++) begin
               for (int b = 0; b < DW; b++) begin
                  for (int v = 0; v < 2; v++) begin
                     bit hits1;
                     fa_en = 1'b1; fa_addr = a;
                     fa_mask = DW'(1) << b;
                     fa_val  = v[0] ? fa_mask : '0;
                     hits1 = (((a >> b) & 1) != v);
                     run(1'b1, a, hits1 ? (N + a + 2) : (4*N + a + 2), 1'b0, 1'b0);
                  end
               end
            end
            fa_en = 1'b0;
            // R3: aliased upper half caught at address 0 in the first sweep
            alias_en = 1'b1;
            run(1'b1, 0, N + 2, 1'b0, 1'b0);
            alias_en = 1'b0;
            // R7: first in time wins (9 fails in pass one, 3 only in pass two)
            fa_en = 1'b1; fa_addr = 9; fa_mask = 8'h01; fa_val = 8'h00;
            fb_en = 1'b1; fb_addr = 3; fb_mask = 8'h80; fb_val = 8'h00;
            run(1'b1, 9, N + 9 + 2, 1'b0, 1'b0);
            fa_en = 1'b0; fb_en = 1'b0;
            // R9: restart after failure returns to a clean pass
            run(1'b0, 0, 5*N + 1, 1'b0, 1'b1);
         end
         begin
            wait (wd_hit);
            chk(1'b0, "watchdog", 0, 1);
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule